// File: doc/BRIEF.md
# 8-bit ALU with status flags

An 8-bit arithmetic and logic unit for a small processor datapath. The result is formed combinationally from two operands, an operation code and the carry held in the unit's own status register. The six status flags are stored in that register and are only rewritten on a clock edge when the flag-write enable is high. Each operation rewrites only the flags that belong to it, and leaves every other flag as it was.

Besides the byte operations, the unit has a word mode. In word mode `a_hi:a` is treated as one 16-bit value, and a 6-bit unsigned immediate taken from `b[5:0]` is added to it or subtracted from it. Set-bits and clear-bits are done with OR and AND: the caller supplies K, or the inverse of K.

Top module: `alu8_flags`

## Requirements
- R1: Flag vector bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. While `rst_n` is low, all flags read 0.
- R2: Op 0 (add) and op 1 (add with carry; the stored C is added) set `result` to the low 8 bits of the sum. They write C as the carry out of bit 7, H as the carry out of bit 3, V as two's-complement overflow, and N as result bit 7. Z is set when the result is zero.
- R3: Op 2 (subtract), op 3 (subtract with carry; the stored C is also subtracted) and op 8 (negate, 0 - a) write C as the borrow out of bit 7 and H as the borrow into bit 4. They also write V, N and Z (Z non-sticky for op 2 and op 8).
- R4: Op 4 (AND), op 5 (OR), op 6 (XOR), op 9 (a+1) and op 10 (a-1) write Z and N from the result and clear V. C and H keep their values.
- R5: Op 7 gives 0xFF - a. It sets C, clears V, writes Z and N, and keeps H.
- R6: For op 3 and op 12, Z is cleared when the 8-bit result is nonzero and otherwise keeps its prior value.
- R7: Op 11 (compare) and op 12 (compare with carry) set flags as op 2 and op 3 do, while `result` shows `a` unchanged.
- R8: Op 13 (word add) and op 14 (word subtract) drive `{result_hi,result}` with `{a_hi,a}` plus or minus `b[5:0]`. They write C (carry or borrow out of bit 15), Z (all 16 bits zero), N (bit 15) and V (16-bit signed overflow), and keep H. For every other op, `result_hi` is 0.
- R9: After any flag write, S equals N XOR V.
- R10: With `flag_we` low, the flag register keeps its value through the clock edge.
- R11: Op 15 passes `a` to `result` and leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 4 | Operation code |
| a | input | 8 | First operand; low byte in word mode |
| a_hi | input | 8 | High byte of the word operand |
| b | input | 8 | Second operand; bits 5:0 are the word immediate |
| flag_we | input | 1 | Flag register write enable |
| result | output | 8 | Combinational result, low byte |
| result_hi | output | 8 | Combinational result, high byte in word mode |
| flags | output | 6 | Stored status flags |

## Verification
Two things can happen in the same cycle: an operation reads the stored carry, and the same clock edge overwrites that carry. Sticky Z for the carry-chained subtract also depends on the stored Z while that bit is being rewritten. The bench runs subtract-with-carry and add-with-carry back to back with the enable high, so each result depends on the previous cycle's flags. It also inserts cycles with the enable low in between, to prove the old carry is still used. A behavioural model carries its own flag state from step to step and predicts both the combinational result before the edge and the stored flags after it.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W  = 8,
  parameter int KW = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] a_hi,
  input  logic [W-1:0] b,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic [W-1:0] result_hi,
  output logic [5:0]   flags
);
  localparam int HB = W / 2;
  localparam int WW = 2 * W;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_COM = 4'd7;
  localparam logic [3:0] OP_NEG = 4'd8,  OP_INC = 4'd9,  OP_DEC = 4'd10, OP_CP  = 4'd11;
  localparam logic [3:0] OP_CPC = 4'd12, OP_ADW = 4'd13, OP_SBW = 4'd14;

  logic [5:0] flg, nf;
  assign flags = flg;

  logic cin, bin;
  assign cin = (op == OP_ADC) & flg[FC];
  assign bin = ((op == OP_SBC) | (op == OP_CPC)) & flg[FC];

  logic [W:0] add_s;
  logic [HB:0] add_h;
  assign add_s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign add_h = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};

  logic [W-1:0] sx, sy;
  assign sx = (op == OP_NEG) ? '0 : a;
  assign sy = (op == OP_NEG) ? a : b;

  logic [W:0] sub_d;
  logic [HB:0] sub_h;
  assign sub_d = {1'b0, sx} - {1'b0, sy} - {{W{1'b0}}, bin};
  assign sub_h = {1'b0, sx[HB-1:0]} - {1'b0, sy[HB-1:0]} - {{HB{1'b0}}, bin};

  logic add_v, sub_v;
  assign add_v = (a[W-1] == b[W-1]) & (add_s[W-1] != a[W-1]);
  assign sub_v = (sx[W-1] != sy[W-1]) & (sub_d[W-1] != sx[W-1]);

  logic [WW-1:0] wx, wk;
  logic [WW:0]   ws, wd;
  assign wx = {a_hi, a};
  assign wk = {{(WW-KW){1'b0}}, b[KW-1:0]};
  assign ws = {1'b0, wx} + {1'b0, wk};
  assign wd = {1'b0, wx} - {1'b0, wk};

  logic [W-1:0] inc_r, dec_r, log_r;
  assign inc_r = a + 1'b1;
  assign dec_r = a - 1'b1;
  always_comb begin
    case (op)
      OP_AND:  log_r = a & b;
      OP_OR:   log_r = a | b;
      OP_XOR:  log_r = a ^ b;
      OP_INC:  log_r = inc_r;
      default: log_r = dec_r;
    endcase
  end

  always_comb begin
    result    = a;
    result_hi = '0;
    nf        = flg;
    case (op)
      OP_ADD, OP_ADC: begin
        result  = add_s[W-1:0];
        nf[FC]  = add_s[W];
        nf[FH]  = add_h[HB];
        nf[FV]  = add_v;
        nf[FN]  = add_s[W-1];
        nf[FZ]  = (add_s[W-1:0] == '0);
      end
      OP_SUB, OP_SBC, OP_NEG, OP_CP, OP_CPC: begin
        if (op != OP_CP && op != OP_CPC) result = sub_d[W-1:0];
        nf[FC]  = sub_d[W];
        nf[FH]  = sub_h[HB];
        nf[FV]  = sub_v;
        nf[FN]  = sub_d[W-1];
        if (op == OP_SBC || op == OP_CPC)
          nf[FZ] = flg[FZ] & (sub_d[W-1:0] == '0);
        else
          nf[FZ] = (sub_d[W-1:0] == '0);
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        result  = log_r;
        nf[FV]  = 1'b0;
        nf[FN]  = log_r[W-1];
        nf[FZ]  = (log_r == '0);
      end
      OP_COM: begin
        result  = ~a;
        nf[FC]  = 1'b1;
        nf[FV]  = 1'b0;
        nf[FN]  = ~a[W-1];
        nf[FZ]  = (a == '1);
      end
      OP_ADW: begin
        {result_hi, result} = ws[WW-1:0];
        nf[FC]  = ws[WW];
        nf[FV]  = ~wx[WW-1] & ws[WW-1];
        nf[FN]  = ws[WW-1];
        nf[FZ]  = (ws[WW-1:0] == '0);
      end
      OP_SBW: begin
        {result_hi, result} = wd[WW-1:0];
        nf[FC]  = wd[WW];
        nf[FV]  = wx[WW-1] & ~wd[WW-1];
        nf[FN]  = wd[WW-1];
        nf[FZ]  = (wd[WW-1:0] == '0);
      end
      default: ;
    endcase
    nf[FS] = nf[FN] ^ nf[FV];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flg <= '0;
    else if (flag_we) flg <= nf;
  end
endmodule

module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op,
  input logic       flag_we,
  input logic [5:0] flags
);
  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));

  p_logic_keeps_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op inside {4'd4, 4'd5, 4'd6, 4'd9, 4'd10}))
      |=> (flags[0] == $past(flags[0])) && (flags[5] == $past(flags[5])) && !flags[3]);

  p_com_forces_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op == 4'd7) |=> flags[0] && !flags[3]);

  p_sticky_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op == 4'd3 || op == 4'd12) && !flags[1]) |=> !flags[1]);

  p_word_keeps_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op == 4'd13 || op == 4'd14)) |=> (flags[5] == $past(flags[5])));

  p_sign_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] == (flags[2] ^ flags[3]));

  p_pass_keeps_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd15) |=> $stable(flags));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .flag_we(flag_we), .flags(flags)
);

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] op = 4'd15;
  logic [7:0] a = 0, a_hi = 0, b = 0;
  logic       flag_we = 0;
  logic [7:0] result, result_hi;
  logic [5:0] flags;

  int checks = 0, fails = 0;
  int mf[6];
  int exp_r, exp_rh;
  int nfl[6];
  bit done = 0;

  always #10 clk = ~clk;

  alu8_flags uut (.clk(clk), .rst_n(rst_n), .op(op), .a(a), .a_hi(a_hi), .b(b),
                  .flag_we(flag_we), .result(result), .result_hi(result_hi), .flags(flags));

  function automatic string tag_of(int o, bit we);
    if (!we) return "R10";
    case (o)
      0, 1: return "R2";
      2, 3, 8: return "R3";
      4, 5, 6, 9, 10: return "R4";
      7: return "R5";
      11, 12: return "R7";
      13, 14: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic int sgn8(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic check(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic model(int o, int x, int xh, int y);
    int s, ss, hh, w, k;
    for (int i = 0; i < 6; i++) nfl[i] = mf[i];
    exp_r = x; exp_rh = 0;
    case (o)
      0, 1: begin
        int c = (o == 1) ? mf[0] : 0;
        s = x + y + c; ss = sgn8(x) + sgn8(y) + c;
        hh = (x % 16) + (y % 16) + c;
        exp_r = s % 256;
        nfl[0] = s > 255; nfl[5] = hh > 15; nfl[3] = (ss > 127 || ss < -128);
        nfl[2] = exp_r >= 128; nfl[1] = exp_r == 0;
      end
      2, 3, 8, 11, 12: begin
        int p = (o == 8) ? 0 : x;
        int q = (o == 8) ? x : y;
        int c = (o == 3 || o == 12) ? mf[0] : 0;
        int r;
        s = p - q - c; ss = sgn8(p) - sgn8(q) - c;
        hh = (p % 16) - (q % 16) - c;
        r = (s + 512) % 256;
        if (o != 11 && o != 12) exp_r = r;
        nfl[0] = s < 0; nfl[5] = hh < 0; nfl[3] = (ss > 127 || ss < -128);
        nfl[2] = r >= 128;
        nfl[1] = (o == 3 || o == 12) ? (mf[1] != 0 && r == 0) : (r == 0);
      end
      4, 5, 6, 9, 10: begin
        case (o)
          4: exp_r = x & y;
          5: exp_r = x | y;
          6: exp_r = x ^ y;
          9: exp_r = (x + 1) % 256;
          default: exp_r = (x + 255) % 256;
        endcase
        nfl[3] = 0; nfl[2] = exp_r >= 128; nfl[1] = exp_r == 0;
      end
      7: begin
        exp_r = 255 - x;
        nfl[0] = 1; nfl[3] = 0; nfl[2] = exp_r >= 128; nfl[1] = exp_r == 0;
      end
      13, 14: begin
        w = xh * 256 + x; k = y % 64;
        s = (o == 13) ? w + k : w - k;
        ss = ((w > 32767) ? w - 65536 : w) + ((o == 13) ? k : -k);
        exp_r = ((s + 65536) % 65536) % 256;
        exp_rh = ((s + 65536) % 65536) / 256;
        nfl[0] = (s > 65535 || s < 0); nfl[3] = (ss > 32767 || ss < -32768);
        nfl[2] = exp_rh >= 128; nfl[1] = (exp_r == 0 && exp_rh == 0);
      end
      default: ;
    endcase
    if (o != 15) nfl[4] = nfl[2] ^ nfl[3];
  endtask

  function automatic int pack(int f[6]);
    int v = 0;
    for (int i = 0; i < 6; i++) v += (f[i] != 0) << i;
    return v;
  endfunction

  task automatic step(int o, int x, int xh, int y, bit we);
    string t;
    @(negedge clk);
    op = 4'(o); a = 8'(x); a_hi = 8'(xh); b = 8'(y); flag_we = we;
    t = tag_of(o, we);
    model(o, x, xh, y);
    #2;
    check(t, result, exp_r, "result");
    check(t, result_hi, exp_rh, "result_hi");
    @(posedge clk);
    #1;
    if (we) for (int i = 0; i < 6; i++) mf[i] = nfl[i];
    check(t, flags, pack(mf), "flags");
    if (o == 3 || o == 12) check("R6", flags[1], mf[1], "sticky Z");
    check("R9", flags[4], flags[2] ^ flags[3], "S=N^V");
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) mf[i] = 0;
    #25;
    check("R1", flags, 0, "reset flags");
    @(negedge clk); rst_n = 1;
    step(0, 8'h0F, 0, 8'h01, 1);
    step(0, 8'hFF, 0, 8'h01, 1);
    step(1, 8'h10, 0, 8'h20, 1);
    step(0, 8'h7F, 0, 8'h01, 1);
    step(2, 8'h05, 0, 8'h05, 1);
    step(3, 8'h00, 0, 8'h00, 1);
    step(3, 8'h01, 0, 8'h00, 1);
    step(3, 8'h00, 0, 8'h00, 1);
    step(2, 8'h00, 0, 8'h01, 1);
    step(4, 8'hF0, 0, 8'h3C, 0);
    step(1, 8'h00, 0, 8'h00, 1);
    step(12, 8'h10, 0, 8'h10, 1);
    step(11, 8'h80, 0, 8'h01, 1);
    step(4, 8'hF0, 0, 8'h0F, 1);
    step(5, 8'h80, 0, 8'h01, 1);
    step(6, 8'hAA, 0, 8'hAA, 1);
    step(7, 8'hFF, 0, 8'h00, 1);
    step(7, 8'h12, 0, 8'h00, 1);
    step(8, 8'h80, 0, 8'h00, 1);
    step(8, 8'h00, 0, 8'h00, 1);
    step(9, 8'h7F, 0, 8'h00, 1);
    step(10, 8'h00, 0, 8'h00, 1);
    step(13, 8'hFF, 8'hFF, 8'h01, 1);
    step(13, 8'hFF, 8'h7F, 8'hC1, 1);
    step(14, 8'h00, 8'h00, 8'h01, 1);
    step(14, 8'h00, 8'h80, 8'h3F, 1);
    step(15, 8'h5A, 0, 8'h00, 1);
    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 3) != 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule